// File: doc/BRIEF.md
# Row-Register Cached DRAM Controller Core

This block is a cycle-level behavioural model of a dynamic memory array that sits behind a single cache row register. A last-fetched-row tag register records which array row the cache holds. An active-low row strobe opens each memory cycle. On the clock that first sees the strobe low, the block samples the cycle-type inputs and classifies the cycle as one of these: read hit, read miss, write hit, write miss, refresh, or illegal. A read miss copies a whole array row into the cache row register in one clock and loads the tag. A read hit touches only the cache. Writes always go to the array, and they also go to the cache only when the row matches the tag, so cache and array never disagree for the cached row.

All reads come from the cache row register. The row strobe does not have to be active for a read: with select and output enable low, the data output shows the cache entry at the current column. The column comes through a latch that is transparent while its strobe is high and holds while it is low. An optional per-bit mask, presented on the data input when the row strobe falls, limits which data bits the writes of that cycle may change. The array keeps only 2^STORE_ROW_BITS physical rows, indexed by the low row-address bits. The tag compare still uses the full row address.

Top module: `rowcache_dram`

## Requirements
- R1: After reset, cyc_class is 0 and illegal is 0. rfsh_row is 0, and the tag is invalid, so the first read cycle is a read miss whatever its row.
- R2: On the clock at which row_en_n is first seen low, the cycle is classified. cyc_class is encoded as 0 idle, 1 read hit, 2 read miss, 3 write hit, 4 write miss, 5 refresh, 6 illegal. It holds this value until the clock at which row_en_n is seen high again, and then returns to 0. The classification works as follows: rfsh_n low gives refresh. Otherwise wr_rd=0 gives a read and wr_rd=1 gives a write. The cycle is a hit when the tag is valid and equals the full 11-bit addr.
- R3: A read miss copies every column of array row addr[STORE_ROW_BITS-1:0] into the cache row register and loads the tag with addr.
- R4: A read hit does not reload the cache. After a write miss to a row that shares the array row of the tagged row, a read hit still returns the old cache data.
- R5: On a write hit, each write updates both the array and the cache entry at that column.
- R6: On a write miss, each write updates only the array. The cache and the tag are unchanged.
- R7: A write takes place on each clock where the cycle is a write cycle and both col_lat_n and we_n are low. A write cycle in which col_lat_n never goes low changes no data.
- R8: While col_lat_n is high, the column is addr[8:0] directly and is also captured. While col_lat_n is low, the column captured on the last clock with col_lat_n high is used.
- R9: With MASK_EN=1, din is captured as a bit mask when a write cycle is classified. A mask bit of 1 lets that data bit be written and a 0 keeps the old bit. The same mask applies to every write of that cycle.
- R10: dout_en is 1 when cs_n and oe_n are both low, except during a write-miss cycle and for RECOV_CYC (>=1) clocks after the clock that ends one. dout equals the cache entry at the current column when dout_en is 1, and 0 otherwise.
- R11: With rfsh_n high, a cycle is illegal (class 6, illegal=1) if any of these holds when it starts: cs_n is high, col_lat_n is low, or wr_rd is high with we_n low. An illegal cycle changes neither the tag, the cache nor the array.
- R12: A refresh cycle changes no data or tag, and rfsh_row increases by 1 on the clock that ends it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| row_en_n | input | 1 | Active-low row strobe that opens a memory cycle |
| wr_rd | input | 1 | Cycle direction: 1 write, 0 read |
| rfsh_n | input | 1 | Active-low refresh request sampled at cycle start |
| col_lat_n | input | 1 | Column latch strobe (transparent when high) |
| we_n | input | 1 | Active-low write strobe |
| oe_n | input | 1 | Active-low output enable |
| addr | input | ROW_W | Multiplexed row/column address |
| din | input | DQ_W | Write data; write mask at cycle start |
| dout | output | DQ_W | Cache read data (0 when disabled) |
| dout_en | output | 1 | Output driver enable |
| cyc_class | output | 3 | Class of the open cycle |
| illegal | output | 1 | Open cycle is illegal |
| rfsh_row | output | ROW_W | Internal refresh row counter |

## Verification
Two things can fall in the same clock: a cache read on the output and a write hit that updates the column being read. The bench keeps select and output enable low for the whole of each write cycle. At the sample point after the write clock it compares dout with the masked merge that its reference array and shadow cache predict, so any read of the stale entry would fail. The same sample in a write-miss cycle must show the output disabled. The following reads of the same row then confirm the value in the cache, and the ones after a row change confirm the value in the array.

// File: rtl/rc_pkg.sv
// Shared cycle classification for the row-register cached DRAM core.
package rc_pkg;
    typedef enum logic [2:0] {
        CY_IDLE    = 3'd0,
        CY_RD_HIT  = 3'd1,
        CY_RD_MISS = 3'd2,
        CY_WR_HIT  = 3'd3,
        CY_WR_MISS = 3'd4,
        CY_RFSH    = 3'd5,
        CY_BAD     = 3'd6
    } cyc_e;
endpackage

// File: rtl/rc_cycle_ctl.sv
// Cycle controller: finds the row-strobe edges, classifies each cycle at its
// start, keeps the last-fetched-row tag, the column latch, the write mask
// and the refresh counter. Assumes COL_W <= ROW_W and STORE_ROW_BITS <= ROW_W.
module rc_cycle_ctl
    import rc_pkg::*;
#(
    parameter int ROW_W          = 11,
    parameter int COL_W          = 9,
    parameter int DQ_W           = 4,
    parameter int STORE_ROW_BITS = 2,
    parameter int MASK_EN        = 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      row_en_n,
    input  logic                      cs_n,
    input  logic                      wr_rd,
    input  logic                      rfsh_n,
    input  logic                      col_lat_n,
    input  logic                      we_n,
    input  logic [ROW_W-1:0]          addr,
    input  logic [DQ_W-1:0]           din,
    output cyc_e                      cls_q,
    output logic                      miss_load,
    output logic [STORE_ROW_BITS-1:0] fetch_row,
    output logic [STORE_ROW_BITS-1:0] row_q,
    output logic [COL_W-1:0]          col_now,
    output logic                      wr_en,
    output logic                      wr_hit,
    output logic [DQ_W-1:0]           mask_q,
    output logic                      row_rise,
    output logic [ROW_W-1:0]          rfsh_row
);
    localparam logic [ROW_W-1:0] ONE_ROW = 1;

    logic             prev_n;
    logic             row_fall;
    logic [ROW_W-1:0] lrr_q;
    logic             lrr_ok;
    logic             tag_match;
    logic [COL_W-1:0] col_q;
    cyc_e             cls_new;

    assign row_fall  = prev_n & ~row_en_n;
    assign row_rise  = ~prev_n & row_en_n;
    assign tag_match = lrr_ok && (addr == lrr_q);

    // Decide the class of a cycle from the strobes present at its start.
    always_comb begin
        if (!rfsh_n)
            cls_new = CY_RFSH;
        else if (cs_n || !col_lat_n || (wr_rd && !we_n))
            cls_new = CY_BAD;
        else if (!wr_rd)
            cls_new = tag_match ? CY_RD_HIT : CY_RD_MISS;
        else
            cls_new = tag_match ? CY_WR_HIT : CY_WR_MISS;
    end

    assign miss_load = row_fall && (cls_new == CY_RD_MISS);
    assign fetch_row = addr[STORE_ROW_BITS-1:0];
    assign col_now   = col_lat_n ? addr[COL_W-1:0] : col_q;
    assign wr_hit    = (cls_q == CY_WR_HIT);
    assign wr_en     = ((cls_q == CY_WR_HIT) || (cls_q == CY_WR_MISS))
                       && !row_en_n && !col_lat_n && !we_n;

    // Track the previous row-strobe level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_n <= 1'b1;
        else        prev_n <= row_en_n;
    end

    // Hold the cycle class, write row and mask for the open cycle; count refreshes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cls_q    <= CY_IDLE;
            row_q    <= '0;
            mask_q   <= '1;
            rfsh_row <= '0;
        end else if (row_fall) begin
            cls_q <= cls_new;
            row_q <= addr[STORE_ROW_BITS-1:0];
            if (cls_new == CY_WR_HIT || cls_new == CY_WR_MISS)
                mask_q <= (MASK_EN != 0) ? din : '1;
        end else if (row_rise) begin
            cls_q <= CY_IDLE;
            if (cls_q == CY_RFSH)
                rfsh_row <= rfsh_row + ONE_ROW;
        end
    end

    // Load the tag only on a read miss.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lrr_q  <= '0;
            lrr_ok <= 1'b0;
        end else if (miss_load) begin
            lrr_q  <= addr;
            lrr_ok <= 1'b1;
        end
    end

    // Column latch: follows addr while the strobe is high.
    always_ff @(posedge clk) begin
        if (!rst_n)         col_q <= '0;
        else if (col_lat_n) col_q <= addr[COL_W-1:0];
    end

    assert_class_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!row_fall && !row_rise) |=> $stable(cls_q));

    assert_tag_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        miss_load |=> (lrr_q == $past(addr)));

    assert_wmiss_keeps_tag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cls_q == CY_WR_MISS) |=> $stable(lrr_q));

    assert_rfsh_step_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (row_rise && cls_q == CY_RFSH) |=> (rfsh_row == $past(rfsh_row) + ONE_ROW));
endmodule

// File: rtl/rc_storage.sv
// Behavioural array plus cache row register. Copies a whole array row into the
// cache in one clock and applies masked writes to the array and, on hits, to
// the cache. Assumes load and write never share a clock.
module rc_storage #(
    parameter int STORE_ROW_BITS = 2,
    parameter int COL_W          = 9,
    parameter int DQ_W           = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      load,
    input  logic [STORE_ROW_BITS-1:0] load_row,
    input  logic                      wr_en,
    input  logic                      wr_hit,
    input  logic [STORE_ROW_BITS-1:0] wr_row,
    input  logic [COL_W-1:0]          col,
    input  logic [DQ_W-1:0]           wdata,
    input  logic [DQ_W-1:0]           mask,
    output logic [DQ_W-1:0]           rd_data
);
    localparam int COLS  = 1 << COL_W;
    localparam int WORDS = (1 << STORE_ROW_BITS) * COLS;
    localparam int AW    = STORE_ROW_BITS + COL_W;

    logic [DQ_W-1:0] arr   [WORDS];
    logic [DQ_W-1:0] cache [COLS];
    logic [AW-1:0]   wr_idx;
    logic [DQ_W-1:0] arr_new;
    logic [DQ_W-1:0] cache_new;

    // Merge new data into the old word under the mask.
    always_comb begin
        wr_idx    = {wr_row, col};
        arr_new   = (arr[wr_idx] & ~mask) | (wdata & mask);
        cache_new = (cache[col] & ~mask) | (wdata & mask);
    end

    // Row fill on a read miss; masked write to array and, on a hit, to cache.
    always_ff @(posedge clk) begin
        if (load) begin
            for (int c = 0; c < COLS; c++)
                cache[c] <= arr[{load_row, COL_W'(c)}];
        end
        if (wr_en) begin
            arr[wr_idx] <= arr_new;
            if (wr_hit) cache[col] <= cache_new;
        end
    end

    assign rd_data = cache[col];

    assert_no_fill_on_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && wr_en));
endmodule

// File: rtl/rc_read_gate.sv
// Output gating: enables the data output on select and output enable, and
// keeps it off through a write-miss cycle and a recovery window after it.
// Assumes RECOV_CYC >= 1.
module rc_read_gate #(
    parameter int RECOV_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic oe_n,
    input  logic wm_active,
    input  logic wm_end,
    output logic dout_en
);
    localparam int CW = $clog2(RECOV_CYC + 2);

    logic [CW-1:0] rec_cnt;

    // Recovery counter: loaded at the end of a write miss, runs down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)              rec_cnt <= '0;
        else if (wm_end)         rec_cnt <= CW'(RECOV_CYC);
        else if (rec_cnt != '0)  rec_cnt <= rec_cnt - CW'(1);
    end

    assign dout_en = !cs_n && !oe_n && !wm_active && (rec_cnt == '0);

    assert_recovery_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wm_end |=> !dout_en);
endmodule

// File: rtl/rowcache_dram.sv
// Top of the row-register cached DRAM core. Wires the cycle controller, the
// array/cache storage and the output gate. Assumes synchronous strobes.
module rowcache_dram
    import rc_pkg::*;
#(
    parameter int ROW_W          = 11,
    parameter int COL_W          = 9,
    parameter int DQ_W           = 4,
    parameter int STORE_ROW_BITS = 2,
    parameter int MASK_EN        = 1,
    parameter int RECOV_CYC      = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             row_en_n,
    input  logic             wr_rd,
    input  logic             rfsh_n,
    input  logic             col_lat_n,
    input  logic             we_n,
    input  logic             oe_n,
    input  logic [ROW_W-1:0] addr,
    input  logic [DQ_W-1:0]  din,
    output logic [DQ_W-1:0]  dout,
    output logic             dout_en,
    output logic [2:0]       cyc_class,
    output logic             illegal,
    output logic [ROW_W-1:0] rfsh_row
);
    cyc_e                      cls_q;
    logic                      miss_load;
    logic [STORE_ROW_BITS-1:0] fetch_row;
    logic [STORE_ROW_BITS-1:0] row_q;
    logic [COL_W-1:0]          col_now;
    logic                      wr_en;
    logic                      wr_hit;
    logic [DQ_W-1:0]           mask_q;
    logic                      row_rise;
    logic [DQ_W-1:0]           rd_data;

    rc_cycle_ctl #(
        .ROW_W(ROW_W), .COL_W(COL_W), .DQ_W(DQ_W),
        .STORE_ROW_BITS(STORE_ROW_BITS), .MASK_EN(MASK_EN)
    ) u_ctl (
        .clk(clk), .rst_n(rst_n), .row_en_n(row_en_n), .cs_n(cs_n),
        .wr_rd(wr_rd), .rfsh_n(rfsh_n), .col_lat_n(col_lat_n), .we_n(we_n),
        .addr(addr), .din(din), .cls_q(cls_q), .miss_load(miss_load),
        .fetch_row(fetch_row), .row_q(row_q), .col_now(col_now),
        .wr_en(wr_en), .wr_hit(wr_hit), .mask_q(mask_q),
        .row_rise(row_rise), .rfsh_row(rfsh_row)
    );

    rc_storage #(
        .STORE_ROW_BITS(STORE_ROW_BITS), .COL_W(COL_W), .DQ_W(DQ_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .load(miss_load), .load_row(fetch_row),
        .wr_en(wr_en), .wr_hit(wr_hit), .wr_row(row_q), .col(col_now),
        .wdata(din), .mask(mask_q), .rd_data(rd_data)
    );

    rc_read_gate #(
        .RECOV_CYC(RECOV_CYC)
    ) u_gate (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .oe_n(oe_n),
        .wm_active(cls_q == CY_WR_MISS),
        .wm_end(row_rise && (cls_q == CY_WR_MISS)),
        .dout_en(dout_en)
    );

    assign dout      = dout_en ? rd_data : '0;
    assign cyc_class = cls_q;
    assign illegal   = (cls_q == CY_BAD);

    assert_illegal_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> !wr_en);
endmodule

// File: tb/tb_rowcache_dram.sv
// Self-checking bench: a vector table of cycles checked against a reference
// array and shadow cache, then directed tests for reset and corner cases.
module tb_rowcache_dram;
    localparam int SRB  = 2;
    localparam int COLS = 512;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b0, row_en_n = 1'b1, wr_rd = 1'b0, rfsh_n = 1'b1;
    logic        col_lat_n = 1'b1, we_n = 1'b1, oe_n = 1'b0;
    logic [10:0] addr = '0;
    logic [3:0]  din = '0;
    logic [3:0]  dout;
    logic        dout_en;
    logic [2:0]  cyc_class;
    logic        illegal;
    logic [10:0] rfsh_row;

    int checks = 0;
    int fails  = 0;

    logic [3:0]  ref_arr   [(1<<SRB)*COLS];
    logic [3:0]  ref_cache [COLS];
    logic [10:0] ref_lrr = '0;
    bit          ref_ok  = 1'b0;

    rowcache_dram dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .row_en_n(row_en_n),
        .wr_rd(wr_rd), .rfsh_n(rfsh_n), .col_lat_n(col_lat_n), .we_n(we_n),
        .oe_n(oe_n), .addr(addr), .din(din), .dout(dout), .dout_en(dout_en),
        .cyc_class(cyc_class), .illegal(illegal), .rfsh_row(rfsh_row)
    );

    always #10 clk = ~clk;

    // kind: 0 read, 1 write, 2 write without column strobe, 3 refresh
    typedef struct packed {
        logic [1:0]  kind;
        logic [10:0] row;
        logic [8:0]  col;
        logic [3:0]  data;
        logic [3:0]  mask;
        logic [2:0]  cls;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t TAB [NV] = '{
        '{2'd1, 11'd1, 9'd3,   4'hA, 4'hF, 3'd4},
        '{2'd1, 11'd1, 9'd100, 4'h5, 4'hF, 3'd4},
        '{2'd1, 11'd2, 9'd3,   4'h9, 4'hF, 3'd4},
        '{2'd0, 11'd1, 9'd3,   4'h0, 4'h0, 3'd2},
        '{2'd0, 11'd1, 9'd100, 4'h0, 4'h0, 3'd1},
        '{2'd1, 11'd1, 9'd3,   4'hC, 4'hF, 3'd3},
        '{2'd0, 11'd1, 9'd3,   4'h0, 4'h0, 3'd1},
        '{2'd1, 11'd2, 9'd3,   4'h6, 4'hF, 3'd4},
        '{2'd0, 11'd1, 9'd3,   4'h0, 4'h0, 3'd1},
        '{2'd0, 11'd2, 9'd3,   4'h0, 4'h0, 3'd2},
        '{2'd0, 11'd1, 9'd3,   4'h0, 4'h0, 3'd2},
        '{2'd1, 11'd1, 9'd3,   4'h0, 4'h5, 3'd3},
        '{2'd0, 11'd1, 9'd3,   4'h0, 4'h0, 3'd1},
        '{2'd2, 11'd1, 9'd3,   4'hF, 4'hF, 3'd3},
        '{2'd0, 11'd1, 9'd3,   4'h0, 4'h0, 3'd1},
        '{2'd3, 11'd0, 9'd0,   4'h0, 4'h0, 3'd5},
        '{2'd0, 11'd5, 9'd3,   4'h0, 4'h0, 3'd2},
        '{2'd1, 11'd1, 9'd3,   4'h3, 4'hF, 3'd4},
        '{2'd0, 11'd5, 9'd3,   4'h0, 4'h0, 3'd1},
        '{2'd0, 11'd1, 9'd3,   4'h0, 4'h0, 3'd2},
        '{2'd1, 11'd1, 9'd511, 4'h7, 4'hF, 3'd3},
        '{2'd0, 11'd1, 9'd511, 4'h0, 4'h0, 3'd1}
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] merge(input logic [3:0] old, input logic [3:0] d,
                                         input logic [3:0] m);
        return (old & ~m) | (d & m);
    endfunction

    task automatic idle_strobes();
        row_en_n = 1'b1; wr_rd = 1'b0; rfsh_n = 1'b1;
        col_lat_n = 1'b1; we_n = 1'b1; cs_n = 1'b0; oe_n = 1'b0;
    endtask

    // One read cycle: open row, check class, read one column from the cache.
    task automatic rd_cycle(input logic [10:0] row, input logic [8:0] col,
                            input logic [2:0] exp_cls, input string tag);
        @(negedge clk);
        wr_rd = 1'b0; rfsh_n = 1'b1; col_lat_n = 1'b1; we_n = 1'b1;
        addr = row; row_en_n = 1'b0;
        @(negedge clk);
        chk(cyc_class == exp_cls, {tag, " R2 class"}, cyc_class, exp_cls);
        if (exp_cls == 3'd2) begin
            ref_lrr = row; ref_ok = 1'b1;
            for (int c = 0; c < COLS; c++) ref_cache[c] = ref_arr[{row[SRB-1:0], 9'(c)}];
        end
        addr = {2'b00, col};
        #2;
        chk(dout_en && dout == ref_cache[col], {tag, " R3 read data"}, dout, ref_cache[col]);
        @(negedge clk);
        row_en_n = 1'b1;
        @(negedge clk);
    endtask

    // One write cycle: mask at start, optional column-strobed write, end.
    task automatic wr_cycle(input logic [10:0] row, input logic [8:0] col,
                            input logic [3:0] data, input logic [3:0] mask,
                            input bit do_cal, input logic [2:0] exp_cls,
                            input string tag);
        bit hit;
        hit = ref_ok && (row == ref_lrr);
        @(negedge clk);
        wr_rd = 1'b1; rfsh_n = 1'b1; col_lat_n = 1'b1; we_n = 1'b1;
        addr = row; din = mask; row_en_n = 1'b0;
        @(negedge clk);
        chk(cyc_class == exp_cls, {tag, " R2 class"}, cyc_class, exp_cls);
        addr = {2'b00, col}; din = data;
        @(negedge clk);
        if (do_cal) begin
            col_lat_n = 1'b0; we_n = 1'b0;
        end
        @(negedge clk);
        if (do_cal) begin
            ref_arr[{row[SRB-1:0], col}] = merge(ref_arr[{row[SRB-1:0], col}], data, mask);
            if (hit) ref_cache[col] = merge(ref_cache[col], data, mask);
        end
        if (hit)
            chk(dout_en && dout == ref_cache[col], {tag, " R5 same-clock read"}, dout, ref_cache[col]);
        else
            chk(!dout_en && dout == 4'h0, {tag, " R10 miss inhibit"}, dout_en, 0);
        col_lat_n = 1'b1; we_n = 1'b1;
        @(negedge clk);
        row_en_n = 1'b1; wr_rd = 1'b0;
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic rf_cycle(input string tag);
        @(negedge clk);
        rfsh_n = 1'b0; row_en_n = 1'b0;
        @(negedge clk);
        chk(cyc_class == 3'd5, {tag, " R12 class"}, cyc_class, 5);
        rfsh_n = 1'b1;
        @(negedge clk);
        row_en_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin : main
        for (int i = 0; i < (1<<SRB)*COLS; i++) ref_arr[i] = 4'h0;
        for (int i = 0; i < COLS; i++) ref_cache[i] = 4'h0;
        idle_strobes();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(cyc_class == 3'd0, "R1 class idle", cyc_class, 0);
        chk(illegal == 1'b0, "R1 illegal low", illegal, 0);
        chk(rfsh_row == 11'd0, "R1 refresh counter", rfsh_row, 0);
        // R1: first read after reset misses even at row 0 (data not checked)
        @(negedge clk);
        wr_rd = 1'b0; addr = 11'd0; row_en_n = 1'b0;
        @(negedge clk);
        chk(cyc_class == 3'd2, "R1 first read misses", cyc_class, 2);
        ref_lrr = 11'd0; ref_ok = 1'b1;
        row_en_n = 1'b1;
        @(negedge clk);

        // Vector table walk
        for (int v = 0; v < NV; v++) begin
            case (TAB[v].kind)
                2'd0: rd_cycle(TAB[v].row, TAB[v].col, TAB[v].cls, $sformatf("vec%0d R4", v));
                2'd1: wr_cycle(TAB[v].row, TAB[v].col, TAB[v].data, TAB[v].mask, 1'b1,
                               TAB[v].cls, $sformatf("vec%0d R6", v));
                2'd2: wr_cycle(TAB[v].row, TAB[v].col, TAB[v].data, TAB[v].mask, 1'b0,
                               TAB[v].cls, $sformatf("vec%0d R7", v));
                default: rf_cycle($sformatf("vec%0d", v));
            endcase
        end
        chk(rfsh_row == 11'd1, "R12 counter stepped", rfsh_row, 1);

        // R8 column latch transparency and hold (no row cycle needed)
        @(negedge clk);
        addr = 11'd511; #2;
        chk(dout == ref_cache[511], "R8 transparent", dout, ref_cache[511]);
        @(negedge clk);
        col_lat_n = 1'b0;
        @(negedge clk);
        addr = 11'd3; #2;
        chk(dout == ref_cache[511], "R8 held while low", dout, ref_cache[511]);
        @(negedge clk);
        col_lat_n = 1'b1; #2;
        chk(dout == ref_cache[3], "R8 transparent again", dout, ref_cache[3]);

        // R9 mask applied to both writes of one burst (tag is row 1)
        @(negedge clk);
        wr_rd = 1'b1; addr = 11'd1; din = 4'b0011; row_en_n = 1'b0;
        @(negedge clk);
        chk(cyc_class == 3'd3, "R9 burst is write hit", cyc_class, 3);
        addr = 11'd3; din = 4'hC;
        @(negedge clk);
        col_lat_n = 1'b0; we_n = 1'b0;
        @(negedge clk);
        col_lat_n = 1'b1; we_n = 1'b1; addr = 11'd511; din = 4'h0;
        @(negedge clk);
        col_lat_n = 1'b0; we_n = 1'b0;
        @(negedge clk);
        col_lat_n = 1'b1; we_n = 1'b1;
        @(negedge clk);
        row_en_n = 1'b1; wr_rd = 1'b0;
        ref_arr[{2'd1, 9'd3}]   = merge(ref_arr[{2'd1, 9'd3}], 4'hC, 4'b0011);
        ref_cache[3]            = merge(ref_cache[3], 4'hC, 4'b0011);
        ref_arr[{2'd1, 9'd511}] = merge(ref_arr[{2'd1, 9'd511}], 4'h0, 4'b0011);
        ref_cache[511]          = merge(ref_cache[511], 4'h0, 4'b0011);
        @(negedge clk);
        addr = 11'd3; #2;
        chk(dout == ref_cache[3], "R9 first masked write", dout, ref_cache[3]);
        addr = 11'd511; #2;
        chk(dout == ref_cache[511], "R9 second masked write", dout, ref_cache[511]);

        // R10 recovery window after a write miss (tag is row 1)
        @(negedge clk);
        wr_rd = 1'b1; addr = 11'd3; din = 4'hF; row_en_n = 1'b0;
        @(negedge clk);
        chk(cyc_class == 3'd4 && !dout_en, "R10 inhibited in write miss", dout_en, 0);
        row_en_n = 1'b1; wr_rd = 1'b0;
        @(negedge clk);
        chk(!dout_en, "R10 recovery clock 1", dout_en, 0);
        @(negedge clk);
        chk(!dout_en, "R10 recovery clock 2", dout_en, 0);
        @(negedge clk);
        chk(dout_en, "R10 enabled after recovery", dout_en, 1);
        oe_n = 1'b1; #2;
        chk(!dout_en && dout == 4'h0, "R10 output enable off", dout, 0);
        oe_n = 1'b0; cs_n = 1'b1; #2;
        chk(!dout_en && dout == 4'h0, "R10 select off", dout, 0);

        // R11 illegal read with select high must not move the tag
        @(negedge clk);
        wr_rd = 1'b0; addr = 11'd2; row_en_n = 1'b0;
        @(negedge clk);
        chk(illegal && cyc_class == 3'd6, "R11 deselected read flagged", cyc_class, 6);
        row_en_n = 1'b1; cs_n = 1'b0;
        @(negedge clk);
        chk(!illegal, "R11 flag clears", illegal, 0);
        rd_cycle(11'd1, 9'd3, 3'd1, "R11 tag kept");
        // R11 write started with write strobe low must not write
        @(negedge clk);
        wr_rd = 1'b1; we_n = 1'b0; addr = 11'd1; din = 4'hF; row_en_n = 1'b0;
        @(negedge clk);
        chk(illegal, "R11 early write strobe flagged", illegal, 1);
        addr = 11'd3; din = 4'h9; we_n = 1'b1;
        @(negedge clk);
        col_lat_n = 1'b0; we_n = 1'b0;
        @(negedge clk);
        col_lat_n = 1'b1; we_n = 1'b1;
        @(negedge clk);
        row_en_n = 1'b1; wr_rd = 1'b0;
        @(negedge clk);
        rd_cycle(11'd1, 9'd3, 3'd1, "R11 cache untouched");
        rd_cycle(11'd2, 9'd3, 3'd2, "R11 leave row");
        rd_cycle(11'd1, 9'd3, 3'd2, "R11 array untouched");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule